// File: doc/BRIEF.md
# I2C Controller Interrupt Status, Vector and DMA Request Logic

This block is the event-reporting part of a memory-mapped I2C master controller. The transfer logic raises single-cycle set pulses on a 16-bit status register. A 6-bit enable mask selects which of the low six status sources drive the interrupt line. Two DMA request lines track the receive-ready and transmit-ready status bits when their channels are enabled in a DMA control register. A host port with 16-bit accesses reads and changes this state. Serial bus signalling is handled elsewhere.

A parameter selects one of two register behaviours. The legacy scheme has a read-only status register and a vector register. Each read of the vector register acknowledges exactly one pending source. The newer scheme has no vector. It clears status by writing ones, and it has a test write that raises the six low status sources at once.

Host accesses use `host_en`, `host_wr`, a word address and write data. Read data appears on `host_rdata` one clock after the read request. Register word addresses: 0 status, 1 mask, 2 vector, 3 DMA control, 4 test. Status bit 3 is receive ready and status bit 4 is transmit ready.

Top module: `i2c_irq_dma_ctrl`

## Requirements
- R1: `irq_o` is high when any of status bits 5..0 ANDed with the mask is nonzero. It is registered, so it reflects the status and mask values of the previous cycle.
- R2: `dma_rx_req_o` equals DMA-control bit 15 AND status bit 3. `dma_tx_req_o` equals DMA-control bit 7 AND status bit 4. Both are registered like `irq_o`.
- R3: A write to address 3 stores only bits 15 and 7 of the write data. A read of address 3 returns the stored value.
- R4: A DMA-control write with bit 15 set clears mask bit 3. The same write with bit 7 set clears mask bit 4. Other mask bits are kept.
- R5: A mask write (address 1) keeps write-data bits 5..0 in the newer scheme and bits 4..0 in the legacy scheme. A read of address 1 returns the mask in bits 5..0.
- R6: A status read (address 0) returns the status register with `bus_busy_i` in bit 12. The stored bit 12 is always 0.
- R7: In the newer scheme, a status write clears the status bits selected by (write data AND 0x0027). No other bit changes.
- R8: In the legacy scheme, a status write leaves the status unchanged.
- R9: In the legacy scheme, a vector read (address 2) returns 1 + the index of the lowest set bit of (status[5:0] AND mask) and clears that status bit. When no such bit is set it returns 0.
- R10: In the newer scheme, a vector read returns 0 and changes nothing.
- R11: In the newer scheme, a test write (address 4) with bit 11 set sets status bits 5..0. In the legacy scheme this write has no effect.
- R12: A set pulse on a status bit wins over a clear of that bit in the same cycle.
- R13: `host_rdata` holds the read value in the cycle after a read request. Otherwise it is 0. Unmapped addresses and the test address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en | input | 1 | Host access request this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, one cycle after the read |
| stat_set_i | input | 16 | Single-cycle status set pulses from the transfer logic |
| bus_busy_i | input | 1 | Bus busy indication, shown in status bit 12 |
| irq_o | output | 1 | Interrupt request |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |

## Verification
The bench builds two copies of the block, one with `LEGACY_REV` = 0 and one with `LEGACY_REV` = 1. Both copies get the same stimulus. Only this pairing exercises both the vector acknowledge path and the write-one-to-clear and forced-set paths, and it shows that each scheme ignores the other scheme's accesses. Random traffic with sparse set pulses creates collisions between a set and a clear, and creates vector reads with several sources pending. Directed steps cover the empty vector, the DMA-enable clearing of mask bits and the legacy mask width.

// File: rtl/isr_pkg.sv
// Package: register addresses, field positions and keep masks shared by the
// interrupt/DMA-request block. Assumes a 16-bit host data path.
package isr_pkg;
    localparam int STAT_W   = 16;
    localparam int SRC_W    = 6;
    localparam int HADDR_W  = 3;

    localparam logic [HADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [HADDR_W-1:0] A_MASK   = 3'd1;
    localparam logic [HADDR_W-1:0] A_VECTOR = 3'd2;
    localparam logic [HADDR_W-1:0] A_DMA    = 3'd3;
    localparam logic [HADDR_W-1:0] A_TEST   = 3'd4;

    localparam int BUSY_BIT   = 12;
    localparam int RX_BIT     = 3;
    localparam int TX_BIT     = 4;
    localparam int DMA_RX_EN  = 15;
    localparam int DMA_TX_EN  = 7;
    localparam int FORCE_BIT  = 11;

    localparam logic [STAT_W-1:0] CLR_KEEP  = 16'h0027;
    localparam logic [STAT_W-1:0] DMA_KEEP  = 16'h8080;
    localparam logic [SRC_W-1:0]  MASK_NEW  = 6'h3f;
    localparam logic [SRC_W-1:0]  MASK_OLD  = 6'h1f;
endpackage

// File: rtl/isr_status_reg.sv
// Status register: per-bit sticky flags with set and clear vectors.
// Assumes set_i and clr_i are already qualified by the caller. Set wins over clear.
module isr_status_reg #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_q;

    // Update flags: clear the selected bits first, then apply the set pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o = stat_q;

    // A pulsed bit must be set in the next cycle, even when a clear hit it too.
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

    // A cleared bit with no set pulse must read 0 in the next cycle.
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/isr_lowest_src.sv
// Lowest-set-bit finder over the pending sources. Gives a one-hot pick and
// the vector code (index + 1, or 0 when nothing is pending). Purely combinational.
module isr_lowest_src #(
    parameter int N = 6,
    localparam int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      pend_i,
    output logic [N-1:0]      pick_o,
    output logic [CODE_W-1:0] code_o
);
    // Scan from bit 0 upward. The first pending bit wins.
    always_comb begin
        logic seen;
        seen   = 1'b0;
        pick_o = '0;
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && !seen) begin
                pick_o[i] = 1'b1;
                code_o    = CODE_W'(i + 1);
            end
            seen = seen | pend_i[i];
        end
    end

    // At most one pick, it must be pending, and a pick exists whenever a source is pending.
    always_comb begin
        assert_pick_onehot_R9: assert ($onehot0(pick_o) && ((pick_o & ~pend_i) == '0)
                                       && ((pend_i == '0) == (pick_o == '0)));
    end
endmodule

// File: rtl/isr_out_regs.sv
// Registered interrupt and DMA request outputs. Assumes the inputs are the
// current register values, so the outputs lag any change by one cycle.
module isr_out_regs #(
    parameter int SRC_W = 6,
    parameter int RX_BIT = 3,
    parameter int TX_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] mask_i,
    input  logic             rx_en_i,
    input  logic             tx_en_i,
    output logic             irq_o,
    output logic             drq_rx_o,
    output logic             drq_tx_o
);
    // Register the three request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            drq_rx_o <= 1'b0;
            drq_tx_o <= 1'b0;
        end else begin
            irq_o    <= |(src_i & mask_i);
            drq_rx_o <= rx_en_i & src_i[RX_BIT];
            drq_tx_o <= tx_en_i & src_i[TX_BIT];
        end
    end

    // A DMA request may only be high when its channel was enabled in the previous cycle.
    assert_drq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drq_rx_o || drq_tx_o) |-> (($past(rx_en_i) || !drq_rx_o) && ($past(tx_en_i) || !drq_tx_o)));

    // The interrupt may only rise when some source was unmasked in the previous cycle.
    assert_irq_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(mask_i) != '0));
endmodule

// File: rtl/i2c_irq_dma_ctrl.sv
// Interrupt status, vector and DMA request logic of an I2C master controller.
// Decodes 16-bit host accesses, holds the mask and DMA control, and clears
// status bits in one of two schemes picked by LEGACY_REV. Assumes one host access per cycle.
module i2c_irq_dma_ctrl
    import isr_pkg::*;
#(
    parameter bit LEGACY_REV = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_en,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [STAT_W-1:0]  host_wdata,
    output logic [STAT_W-1:0]  host_rdata,
    input  logic [STAT_W-1:0]  stat_set_i,
    input  logic               bus_busy_i,
    output logic               irq_o,
    output logic               dma_rx_req_o,
    output logic               dma_tx_req_o
);
    localparam int CODE_W = $clog2(SRC_W + 1);
    localparam logic [SRC_W-1:0]  MASK_KEEP = LEGACY_REV ? MASK_OLD : MASK_NEW;
    localparam logic [STAT_W-1:0] NO_BUSY   = ~(STAT_W'(1) << BUSY_BIT);

    logic [STAT_W-1:0] stat_q, set_v, clr_v, rdata_d;
    logic [SRC_W-1:0]  mask_q, pick;
    logic [STAT_W-1:0] dma_q;
    logic [CODE_W-1:0] code;
    logic wr_stat, wr_mask, wr_dma, wr_test, rd_any, rd_vec;

    // Decode the host access.
    always_comb begin
        wr_stat = host_en &&  host_wr && host_addr == A_STATUS;
        wr_mask = host_en &&  host_wr && host_addr == A_MASK;
        wr_dma  = host_en &&  host_wr && host_addr == A_DMA;
        wr_test = host_en &&  host_wr && host_addr == A_TEST;
        rd_any  = host_en && !host_wr;
        rd_vec  = rd_any && host_addr == A_VECTOR;
    end

    isr_lowest_src #(.N(SRC_W)) u_pick (
        .pend_i (stat_q[SRC_W-1:0] & mask_q),
        .pick_o (pick),
        .code_o (code)
    );

    // Build the set and clear vectors for the chosen scheme.
    always_comb begin
        set_v = stat_set_i;
        clr_v = '0;
        if (LEGACY_REV) begin
            if (rd_vec) clr_v = {{(STAT_W-SRC_W){1'b0}}, pick};
        end else begin
            if (wr_stat) clr_v = host_wdata & CLR_KEEP;
            if (wr_test && host_wdata[FORCE_BIT]) set_v = set_v | {{(STAT_W-SRC_W){1'b0}}, {SRC_W{1'b1}}};
        end
        set_v = set_v & NO_BUSY;
    end

    isr_status_reg #(.STAT_W(STAT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .stat_o (stat_q)
    );

    // Mask and DMA control. Enabling a DMA channel drops its mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else if (wr_mask) begin
            mask_q <= host_wdata[SRC_W-1:0] & MASK_KEEP;
        end else if (wr_dma) begin
            dma_q <= host_wdata & DMA_KEEP;
            if (host_wdata[DMA_RX_EN]) mask_q[RX_BIT] <= 1'b0;
            if (host_wdata[DMA_TX_EN]) mask_q[TX_BIT] <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_d = '0;
        case (host_addr)
            A_STATUS: rdata_d = (stat_q & NO_BUSY) | (STAT_W'(bus_busy_i) << BUSY_BIT);
            A_MASK:   rdata_d = {{(STAT_W-SRC_W){1'b0}}, mask_q};
            A_VECTOR: rdata_d = LEGACY_REV ? {{(STAT_W-CODE_W){1'b0}}, code} : '0;
            A_DMA:    rdata_d = dma_q;
            default:  rdata_d = '0;
        endcase
    end

    // Register the read data. It is 0 when there was no read.
    always_ff @(posedge clk) begin
        if (!rst_n)      host_rdata <= '0;
        else if (rd_any) host_rdata <= rdata_d;
        else             host_rdata <= '0;
    end

    isr_out_regs #(.SRC_W(SRC_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (stat_q[SRC_W-1:0]),
        .mask_i   (mask_q),
        .rx_en_i  (dma_q[DMA_RX_EN]),
        .tx_en_i  (dma_q[DMA_TX_EN]),
        .irq_o    (irq_o),
        .drq_rx_o (dma_rx_req_o),
        .drq_tx_o (dma_tx_req_o)
    );

    // A DMA write that enables a channel must leave that channel's mask bit at 0.
    assert_dma_drops_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && host_wdata[DMA_RX_EN]) |=> !mask_q[RX_BIT]);

    // The busy bit is never stored.
    assert_no_stored_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[BUSY_BIT]);

    generate
        if (LEGACY_REV) begin : g_legacy_chk
            // A status write without set pulses leaves the status unchanged.
            assert_status_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stat && stat_set_i == '0) |=> $stable(stat_q));
        end else begin : g_new_chk
            // A vector read without set pulses changes nothing.
            assert_vector_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_vec && stat_set_i == '0) |=> $stable(stat_q));
        end
    endgenerate
endmodule

// File: tb/i2c_irq_dma_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_irq_dma_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        h_en = 0, h_wr = 0, busy = 0;
    logic [2:0]  h_addr = 0;
    logic [15:0] h_wd = 0, setp = 0;
    logic [15:0] rd [2];
    logic        irq [2], drx [2], dtx [2];

    i2c_irq_dma_ctrl #(.LEGACY_REV(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_en(h_en), .host_wr(h_wr), .host_addr(h_addr),
        .host_wdata(h_wd), .host_rdata(rd[0]), .stat_set_i(setp), .bus_busy_i(busy),
        .irq_o(irq[0]), .dma_rx_req_o(drx[0]), .dma_tx_req_o(dtx[0]));

    i2c_irq_dma_ctrl #(.LEGACY_REV(1'b1)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .host_en(h_en), .host_wr(h_wr), .host_addr(h_addr),
        .host_wdata(h_wd), .host_rdata(rd[1]), .stat_set_i(setp), .bus_busy_i(busy),
        .irq_o(irq[1]), .dma_rx_req_o(drx[1]), .dma_tx_req_o(dtx[1]));

    int total = 0, fails = 0;
    logic [15:0] m_st [2];
    logic [5:0]  m_mask [2];
    logic [15:0] m_dma [2];

    task automatic check(input string req, input int k, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dut%0d: actual %h expected %h", req, k, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int k, input logic [2:0] a, input logic b);
        logic [5:0] p;
        p = m_st[k][5:0] & m_mask[k];
        case (a)
            3'd0: return m_st[k] | (16'(b) << 12);
            3'd1: return {10'b0, m_mask[k]};
            3'd2: begin
                if (k == 0) return 16'h0;
                for (int i = 0; i < 6; i++) if (p[i]) return 16'(i + 1);
                return 16'h0;
            end
            3'd3: return m_dma[k];
            default: return 16'h0;
        endcase
    endfunction

    function automatic string read_req(input int k, input logic [2:0] a);
        case (a)
            3'd0: return "R6";
            3'd1: return "R5";
            3'd2: return (k == 1) ? "R9" : "R10";
            3'd3: return "R3";
            default: return "R13";
        endcase
    endfunction

    task automatic model_update(input int k, input logic en, input logic wr, input logic [2:0] a,
                                input logic [15:0] wd, input logic [15:0] sp);
        logic [15:0] clr, frc;
        logic [5:0] p;
        clr = 0; frc = 0;
        p = m_st[k][5:0] & m_mask[k];
        if (en && wr) begin
            case (a)
                3'd0: if (k == 0) clr = wd & 16'h0027;
                3'd1: m_mask[k] = wd[5:0] & ((k == 1) ? 6'h1f : 6'h3f);
                3'd3: begin
                    m_dma[k] = wd & 16'h8080;
                    if (wd[15]) m_mask[k][3] = 1'b0;
                    if (wd[7])  m_mask[k][4] = 1'b0;
                end
                3'd4: if (k == 0 && wd[11]) frc = 16'h003f;
                default: ;
            endcase
        end
        if (en && !wr && a == 3'd2 && k == 1) begin
            for (int i = 0; i < 6; i++) if (p[i]) begin clr = 16'(1) << i; break; end
        end
        m_st[k] = ((m_st[k] & ~clr) | sp | frc) & 16'hefff;
    endtask

    // One bus cycle for both copies; expectations use the state before the edge.
    task automatic step(input logic en, input logic wr, input logic [2:0] a,
                        input logic [15:0] wd, input logic [15:0] sp, input logic b);
        logic [15:0] er [2];
        logic ei [2], ex [2], et [2];
        @(negedge clk);
        h_en = en; h_wr = wr; h_addr = a; h_wd = wd; setp = sp; busy = b;
        for (int k = 0; k < 2; k++) begin
            er[k] = exp_read(k, a, b);
            ei[k] = |(m_st[k][5:0] & m_mask[k]);
            ex[k] = m_dma[k][15] & m_st[k][3];
            et[k] = m_dma[k][7] & m_st[k][4];
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            check("R1", k, 16'(irq[k]), 16'(ei[k]));
            check("R2", k, {14'b0, drx[k], dtx[k]}, {14'b0, ex[k], et[k]});
            if (en && !wr) check(read_req(k, a), k, rd[k], er[k]);
            else           check("R13", k, rd[k], 16'h0);
            model_update(k, en, wr, a, wd, sp);
        end
        h_en = 0; setp = 0;
    endtask

    initial begin
        repeat (800000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        for (int k = 0; k < 2; k++) begin m_st[k] = 0; m_mask[k] = 0; m_dma[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // Reset state: status reads 0 and the requests are low.
        step(1, 0, 3'd0, 0, 0, 0);
        // R9 empty vector returns 0 on the legacy copy.
        step(1, 0, 3'd2, 0, 0, 0);
        // R5 mask width per scheme.
        step(1, 1, 3'd1, 16'hffff, 0, 0);
        step(1, 0, 3'd1, 0, 0, 0);
        // R4 enabling both DMA channels drops mask bits 3 and 4.
        step(1, 1, 3'd3, 16'hffff, 0, 0);
        step(1, 0, 3'd1, 0, 0, 0);
        step(1, 0, 3'd3, 0, 0, 0);
        // R11 forced set on the newer copy only.
        step(1, 1, 3'd4, 16'h0800, 0, 0);
        step(1, 0, 3'd0, 0, 0, 1);
        // R7 / R8 status write of ones.
        step(1, 1, 3'd0, 16'hffff, 0, 0);
        step(1, 0, 3'd0, 0, 0, 0);
        // R12 clear and set of bit 0 in the same cycle.
        step(1, 1, 3'd1, 16'h003f, 16'h0001, 0);
        step(1, 1, 3'd0, 16'h0001, 16'h0001, 0);
        step(1, 0, 3'd0, 0, 0, 0);
        // R9 vector reads drain sources in ascending order.
        step(0, 0, 0, 0, 16'h0026, 0);
        for (int n = 0; n < 5; n++) step(1, 0, 3'd2, 0, 0, 0);
        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            a = 3'($urandom % 6);
            step(1'($urandom % 4 != 0), 1'($urandom % 2), a, 16'($urandom),
                 16'($urandom & $urandom & $urandom), 1'($urandom % 2));
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule